// File: doc/BRIEF.md
# Power-Down Controller with External Override

This block decides, every clock cycle, which of four circuit domains of a synthesizer are powered. The domains are the digital core, the main DAC, the auxiliary DAC and the reference-clock input path. Software holds one power-down bit per domain in a small register that the block owns. An external power-down pin can override all of those bits. A mode input decides what the pin does. In full mode it shuts down everything. In fast-recovery mode the DAC bias and the PLL/VCO/clock-input circuitry stay powered, so the device can wake quickly.

The block also gates the serial register write path. While the digital core is off, writes to any other register are not forwarded. A write to the power-down register then changes only the core bit, so software can always bring the core back. The external pin passes through a synchronizer. Every power control output comes from a flop, so the outputs change without glitches.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While the synchronized external pin is low, each `dom_en` bit equals the inverse of its software power-down bit. Bit 0 is the digital core, bit 1 the main DAC, bit 2 the auxiliary DAC and bit 3 the reference-clock input. A set bit powers the domain down and a cleared bit restores it.
- R2: While the synchronized external pin is high, all `dom_en` bits are 0, whatever the software bits hold.
- R3: While the synchronized pin is high and `fast_recover` is 1, `dac_bias_on` and `clk_path_on` are both 1.
- R4: While the synchronized pin is high and `fast_recover` is 0, `dac_bias_on` and `clk_path_on` are both 0.
- R5: While the synchronized pin is low, `dac_bias_on` is the inverse of software bit 1 and `clk_path_on` is the inverse of software bit 3. `fast_recover` has no effect in this case.
- R6: `wr_fwd` is 1 only when `wr_en` is 1, `wr_pd_sel` is 0 and `dom_en[0]` is 1.
- R7: A write to the power-down register (`wr_en`=1, `wr_pd_sel`=1) while `dom_en[0]` is 0 loads only bit 0 from `wr_data`. Bits 3..1 keep their values. While `dom_en[0]` is 1, all four bits load.
- R8: A change on `ext_pd_pin` reaches the outputs on the (SYNC_STAGES+1)-th rising edge after it is applied. Earlier edges leave the outputs unchanged.
- R9: A power-down register write accepted on rising edge k changes the outputs on edge k+1, not on edge k.
- R10: Reset (`rst_n`=0, synchronous) clears the software bits and the synchronizer. After reset, all `dom_en` bits are 1 and both keep-alive outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pd_pin | input | 1 | Asynchronous external power-down request, active high |
| fast_recover | input | 1 | 1 = fast-recovery override, 0 = full override |
| wr_en | input | 1 | Register write strobe from the serial port |
| wr_pd_sel | input | 1 | 1 = the write targets the power-down register |
| wr_data | input | NUM_DOM | Power-down bits to write |
| dom_en | output | NUM_DOM | Per-domain enable, 1 = powered |
| dac_bias_on | output | 1 | DAC bias keep-alive |
| clk_path_on | output | 1 | PLL/VCO/clock-input keep-alive |
| wr_fwd | output | 1 | Write strobe forwarded to the other registers |

## Verification
The bench builds the block with its default values: NUM_DOM of 4 and a two-stage synchronizer. With these values, the pin latency is a known three edges, so the bench samples the cycle just before and the cycle just after the change. The four domain bits cover every mapping between a software bit and a keep-alive output. The vector table walks software patterns under both override modes. Directed tests then drive the core-off write gating, the core-bit-only register load and the one-cycle register latency.

// File: rtl/pwrdn_pkg.sv
// Package: shared domain indices for the power-down controller.
// Assumes four domains in a fixed order that the output decode relies on.
package pwrdn_pkg;
    localparam int DOM_CORE = 0;  // digital core
    localparam int DOM_DAC  = 1;  // main DAC
    localparam int DOM_AUX  = 2;  // auxiliary DAC
    localparam int DOM_REF  = 3;  // reference-clock input path
    localparam int DOM_MIN  = 4;  // fewest domains the decode needs
endpackage

// File: rtl/pwrdn_sync.sv
// Module: multi-flop synchronizer for the asynchronous external pin.
// Assumes STAGES >= 2. The output is the last flop of the chain.
module pwrdn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], din};
    end

    assign dout = chain[LAST];

    initial begin
        if (STAGES < 2) $error("pwrdn_sync: STAGES must be at least 2");
    end
endmodule

// File: rtl/pwrdn_swreg.sv
// Module: software power-down register with write gating.
// While the core is off, only the core bit accepts write data.
// Assumes the domain order from pwrdn_pkg.
module pwrdn_swreg
    import pwrdn_pkg::*;
#(
    parameter int NUM_DOM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_on,
    input  logic               wr_en,
    input  logic               wr_pd_sel,
    input  logic [NUM_DOM-1:0] wr_data,
    output logic [NUM_DOM-1:0] sw_pd
);
    localparam logic [NUM_DOM-1:0] CORE_MASK = NUM_DOM'(1) << DOM_CORE;

    logic               pd_write;
    logic [NUM_DOM-1:0] load_mask;

    // Pick which bits a write may touch.
    always_comb begin
        pd_write  = wr_en && wr_pd_sel;
        load_mask = core_on ? '1 : CORE_MASK;
    end

    // Hold the bits and load the allowed ones on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_pd <= '0;
        else if (pd_write) sw_pd <= (sw_pd & ~load_mask) | (wr_data & load_mask);
    end

    // R7: with the core off, a register write leaves bits 3..1 alone.
    a_r7_core_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_on && wr_en && wr_pd_sel) |=> (sw_pd[NUM_DOM-1:1] == $past(sw_pd[NUM_DOM-1:1])));
endmodule

// File: rtl/pwrdn_outmap.sv
// Module: registered decode of the software bits and the override into
// domain enables and keep-alive outputs. Assumes ext_s is already
// synchronized. The mode input matters only while the override is active.
module pwrdn_outmap
    import pwrdn_pkg::*;
#(
    parameter int NUM_DOM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_s,
    input  logic               fast_recover,
    input  logic [NUM_DOM-1:0] sw_pd,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               dac_bias_on,
    output logic               clk_path_on
);
    logic [NUM_DOM-1:0] pd_eff;
    logic               bias_nxt;
    logic               clkp_nxt;

    // Combine the override with the software bits.
    always_comb begin
        pd_eff   = ext_s ? '1 : sw_pd;
        bias_nxt = ext_s ? fast_recover : !sw_pd[DOM_DAC];
        clkp_nxt = ext_s ? fast_recover : !sw_pd[DOM_REF];
    end

    // Register every power control output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_en      <= '1;
            dac_bias_on <= 1'b1;
            clk_path_on <= 1'b1;
        end else begin
            dom_en      <= ~pd_eff;
            dac_bias_on <= bias_nxt;
            clk_path_on <= clkp_nxt;
        end
    end

    // R1: software bits drive the enables when there is no override.
    a_r1_sw_control: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_s |=> (dom_en == ~$past(sw_pd)));
    // R2: the override powers down every domain.
    a_r2_override_all: assert property (@(posedge clk) disable iff (!rst_n)
        ext_s |=> (dom_en == '0));
    // R3: fast-recovery override keeps the bias and the clock path alive.
    a_r3_fast_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_s && fast_recover) |=> (dac_bias_on && clk_path_on));
    // R4: full override shuts down the bias and the clock path.
    a_r4_full_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_s && !fast_recover) |=> (!dac_bias_on && !clk_path_on));
    // R5: a software DAC power-down is always a full power-down.
    a_r5_sw_dac_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_s && sw_pd[DOM_DAC]) |=> !dac_bias_on);
    // R10: the cycle after reset, every domain is enabled.
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dom_en == '1 && dac_bias_on && clk_path_on));

    initial begin
        if (NUM_DOM < DOM_MIN) $error("pwrdn_outmap: NUM_DOM too small");
    end
endmodule

// File: rtl/pwrdn_ctrl.sv
// Module: top of the power-down controller. It synchronizes the external
// pin, holds the software bits, decodes the registered outputs and gates
// writes to the other registers while the core is off.
// Assumes the serial write strobe is synchronous to clk.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int NUM_DOM     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pd_pin,
    input  logic               fast_recover,
    input  logic               wr_en,
    input  logic               wr_pd_sel,
    input  logic [NUM_DOM-1:0] wr_data,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               dac_bias_on,
    output logic               clk_path_on,
    output logic               wr_fwd
);
    logic               ext_s;
    logic [NUM_DOM-1:0] sw_pd;
    logic               core_on;

    pwrdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_pd_pin),
        .dout (ext_s)
    );

    pwrdn_swreg #(.NUM_DOM(NUM_DOM)) u_swreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_on  (core_on),
        .wr_en    (wr_en),
        .wr_pd_sel(wr_pd_sel),
        .wr_data  (wr_data),
        .sw_pd    (sw_pd)
    );

    pwrdn_outmap #(.NUM_DOM(NUM_DOM)) u_outmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_s       (ext_s),
        .fast_recover(fast_recover),
        .sw_pd       (sw_pd),
        .dom_en      (dom_en),
        .dac_bias_on (dac_bias_on),
        .clk_path_on (clk_path_on)
    );

    // Core state used to gate the write path.
    assign core_on = dom_en[DOM_CORE];

    // Forward writes for other registers only while the core is powered.
    always_comb wr_fwd = wr_en && !wr_pd_sel && core_on;

    // R6: no write reaches the other registers while the core is off.
    a_r6_gate_writes: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_en[DOM_CORE] |-> !wr_fwd);
endmodule

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
    localparam int ND = 4;
    localparam int NV = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pd_pin = 1'b0;
    logic fast_recover = 1'b0;
    logic wr_en = 1'b0;
    logic wr_pd_sel = 1'b0;
    logic [ND-1:0] wr_data = '0;
    logic [ND-1:0] dom_en;
    logic dac_bias_on, clk_path_on, wr_fwd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrdn_ctrl #(.NUM_DOM(ND), .SYNC_STAGES(2)) u_pwrdn_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pd_pin(ext_pd_pin),
        .fast_recover(fast_recover), .wr_en(wr_en), .wr_pd_sel(wr_pd_sel),
        .wr_data(wr_data), .dom_en(dom_en), .dac_bias_on(dac_bias_on),
        .clk_path_on(clk_path_on), .wr_fwd(wr_fwd)
    );

    // {sw[3:0], ext, fast, en[3:0], bias, clkp}
    localparam logic [11:0] VEC [0:NV-1] = '{
        {4'b0000, 1'b0, 1'b0, 4'b1111, 1'b1, 1'b1},
        {4'b0010, 1'b0, 1'b1, 4'b1101, 1'b0, 1'b1},
        {4'b1000, 1'b0, 1'b1, 4'b0111, 1'b1, 1'b0},
        {4'b0101, 1'b0, 1'b0, 4'b1010, 1'b1, 1'b1},
        {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0},
        {4'b0000, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b1},
        {4'b1111, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b1},
        {4'b1111, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0},
        {4'b0110, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [ND-1:0] act, input logic [ND-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pd_write(input logic [ND-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_pd_sel = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_pd_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 dom_en", dom_en, 4'b1111);
        check("R10 keep", {2'b00, dac_bias_on, clk_path_on}, 4'b0011);
        check("R6 idle", {3'b000, wr_fwd}, 4'b0000);

        // Vector walk: R1..R5
        for (int v = 0; v < NV; v++) begin
            ext_pd_pin = 1'b0;
            wait_cyc(4);
            pd_write(4'b0000);
            wait_cyc(2);
            pd_write(VEC[v][11:8]);
            ext_pd_pin   = VEC[v][7];
            fast_recover = VEC[v][6];
            wait_cyc(5);
            check(VEC[v][7] ? "R2 dom_en" : "R1 dom_en", dom_en, VEC[v][5:2]);
            check(VEC[v][7] ? (VEC[v][6] ? "R3 keep" : "R4 keep") : "R5 keep",
                  {2'b00, dac_bias_on, clk_path_on}, {2'b00, VEC[v][1:0]});
        end

        // Restore a clean state
        ext_pd_pin = 1'b0;
        wait_cyc(4);
        pd_write(4'b0000);
        wait_cyc(2);
        pd_write(4'b0000);
        wait_cyc(2);

        // R8: pin latency is three edges with two stages
        ext_pd_pin = 1'b1; fast_recover = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 before", dom_en, 4'b1111);
        @(negedge clk);
        check("R8 after", dom_en, 4'b0000);
        ext_pd_pin = 1'b0;
        wait_cyc(4);

        // R9: register write shows one edge later
        pd_write(4'b0100);
        check("R9 same edge", dom_en, 4'b1111);
        @(negedge clk);
        check("R9 next edge", dom_en, 4'b1011);

        // R6: write forwarding with core on, then off
        wr_en = 1'b1; wr_pd_sel = 1'b0;
        @(negedge clk);
        check("R6 core on", {3'b000, wr_fwd}, 4'b0001);
        wr_en = 1'b0;
        pd_write(4'b0001);
        @(negedge clk);
        wr_en = 1'b1; wr_pd_sel = 1'b0;
        @(negedge clk);
        check("R6 core off", {3'b000, wr_fwd}, 4'b0000);
        wr_en = 1'b0;

        // R7: with the core off, only bit 0 loads
        pd_write(4'b1111);
        wait_cyc(2);
        check("R7 set others", dom_en, 4'b1110);
        pd_write(4'b1110);
        wait_cyc(2);
        check("R7 clear core", dom_en, 4'b1111);

        // R10: reset again while bits are set
        pd_write(4'b1010);
        wait_cyc(2);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 re-reset", dom_en, 4'b1111);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule